// File: doc/BRIEF.md
# Single-Wire Peripheral Bus Host Command Transmitter

This block is the transmit half of a host controller for a single-wire, open-collector peripheral bus. Given a request, it sends one command frame on the shared line. The line is never driven high: a single enable output pulls the line low, and releasing the enable lets the external pull-up raise it. Because every agent on the line only ever pulls low, the bus behaves as a wired AND.

A frame starts with a long low attention pulse and then a sync bit. Next comes the command byte, built from three fields: a 4-bit device address, a 2-bit command code and a 2-bit register number. The frame ends with a stop bit. When the command is a Listen, the block then waits a fixed stop-to-start gap and sends a data packet. The packet is a start bit, one or two data bytes and a stop bit. Each bit is sent as a fixed-length cell, and the bit value is carried by the share of the cell that is spent low.

All timing comes from a 1 µs tick. A parameterized divider derives the tick from the system clock and restarts it when a request is accepted. The caller raises a one-cycle start with the fields, then waits for busy to drop before sending the next request. Receiving replies, arbitration and collision detection are handled elsewhere.

Top module: `swb_host_tx`

## Requirements
- R1: Out of reset, and whenever busy is low, the line is released (drive_low_o = 0) and busy_o = 0.
- R2: A start_i pulse while busy is low is accepted. busy_o rises and drive_low_o asserts at the same clock edge. start_i, and any change to the request inputs while busy is high, has no effect on the frame in progress.
- R3: The attention low (ATTN_US, default 765 µs) merges with the low part of the sync 1 bit (35 µs). The line is therefore held low for exactly 800 µs from acceptance, with every µs equal to CLK_PER_US clock cycles.
- R4: Every bit cell lasts 100 µs. A 1 is 35 µs low then 65 µs released. A 0 is 65 µs low then 35 µs released.
- R5: After the sync bit, the command byte {addr_i[3:0], code_i[1:0], reg_i[1:0]} is sent MSB first. For example, Listen (code 2'b10) to register 3 of address 2 is 8'h2B.
- R6: After the last command bit, a stop bit is sent as a 0 cell. Without a data phase, busy_o falls at the end of that cell and the line stays released.
- R7: When code_i = 2'b10 (Listen) and len_i is 1 or 2, the line stays released for a 200 µs gap after the command stop cell. The block then sends a 1 start cell, then data0_i and, if len_i is 2, data1_i (each MSB first), then a 0 stop cell. busy_o falls at the end of that stop cell.
- R8: With code_i = 2'b00 (flush), 2'b11 (Talk) or 2'b01, or with a Listen and len_i = 0, no gap and no data packet follow the command stop bit.
- R9: len_i = 3 is treated as 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to send a frame |
| addr_i | input | 4 | Target device address |
| code_i | input | 2 | Command code: 00 flush, 10 Listen, 11 Talk |
| reg_i | input | 2 | Target register number |
| len_i | input | 2 | Data byte count for Listen (0 to 2, 3 acts as 2) |
| data0_i | input | 8 | First data byte |
| data1_i | input | 8 | Second data byte |
| busy_o | output | 1 | High from acceptance until the final stop cell ends |
| drive_low_o | output | 1 | Pull the line low when high; release when low |

## Verification
The bench builds the block with CLK_PER_US = 2 and keeps every duration at its default. Full-length frames, including the 800 µs attention and two-byte Listens, therefore fit in a few thousand cycles each. Because the divider is not 1, the bench also checks that every low and released run is an exact multiple of the divider. A scoreboard turns each request into expected run lengths of the line. It covers sync merging, command and data bits, gap insertion and the length clamp, and it confirms that requests raised mid-frame leave the run list unchanged.

// File: rtl/swb_tx_pkg.sv
package swb_tx_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ATTN,
    PH_CMD,
    PH_GAP,
    PH_DATA
  } phase_e;

  localparam logic [1:0] CODE_FLUSH  = 2'b00;
  localparam logic [1:0] CODE_LISTEN = 2'b10;
  localparam logic [1:0] CODE_TALK   = 2'b11;

  // Command byte: address high nibble, then code, then register
  function automatic logic [7:0] pack_cmd(input logic [3:0] addr,
                                          input logic [1:0] code,
                                          input logic [1:0] regn);
    return {addr, code, regn};
  endfunction

endpackage

// File: rtl/swb_tick_div.sv
module swb_tick_div #(
  parameter int DIV = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  output logic tick_o
);

  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV == 1) begin : g_pass
      assign tick_o = 1'b1;
    end else begin : g_cnt
      logic [DW-1:0] cnt_q, cnt_d;

      assign tick_o = (cnt_q == DW'(DIV-1));

      always_comb begin
        if (clr_i)       cnt_d = '0;
        else if (tick_o) cnt_d = '0;
        else             cnt_d = cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      // R3
      tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o && !clr_i |=> !tick_o);
    end
  endgenerate

endmodule

// File: rtl/swb_bit_cell.sv
module swb_bit_cell #(
  parameter int CELL_US    = 100,
  parameter int ONE_LO_US  = 35,
  parameter int ZERO_LO_US = 65
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic go_i,
  input  logic bit_i,
  output logic low_o,
  output logic done_o
);

  localparam int CNW = $clog2(CELL_US);

  logic           active_q, active_d;
  logic           bit_q, bit_d;
  logic           low_q, low_d;
  logic [CNW-1:0] cnt_q, cnt_d;
  logic [CNW-1:0] lo_len;
  logic           last_us;

  assign lo_len  = bit_q ? CNW'(ONE_LO_US) : CNW'(ZERO_LO_US);
  assign last_us = (cnt_q == CNW'(CELL_US-1));
  assign done_o  = active_q && tick_i && last_us;
  assign low_o   = low_q;

  always_comb begin
    active_d = active_q;
    bit_d    = bit_q;
    low_d    = low_q;
    cnt_d    = cnt_q;
    if (go_i) begin
      active_d = 1'b1;
      bit_d    = bit_i;
      low_d    = 1'b1;
      cnt_d    = '0;
    end else if (active_q && tick_i) begin
      if (last_us) begin
        active_d = 1'b0;
        low_d    = 1'b0;
        cnt_d    = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q + 1'b1 == lo_len) low_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      bit_q    <= 1'b0;
      low_q    <= 1'b0;
      cnt_q    <= '0;
    end else begin
      active_q <= active_d;
      bit_q    <= bit_d;
      low_q    <= low_d;
      cnt_q    <= cnt_d;
    end
  end

  // R4
  low_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_q |-> (cnt_q < CNW'(ZERO_LO_US)));

  // R4
  cell_ends_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !low_q);

endmodule

// File: rtl/swb_host_tx.sv
module swb_host_tx
  import swb_tx_pkg::*;
#(
  parameter int CLK_PER_US = 50,
  parameter int ATTN_US    = 765,
  parameter int CELL_US    = 100,
  parameter int ONE_LO_US  = 35,
  parameter int ZERO_LO_US = 65,
  parameter int GAP_US     = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [3:0] addr_i,
  input  logic [1:0] code_i,
  input  logic [1:0] reg_i,
  input  logic [1:0] len_i,
  input  logic [7:0] data0_i,
  input  logic [7:0] data1_i,
  output logic       busy_o,
  output logic       drive_low_o
);

  localparam int CMD_CELLS = 10;             // sync + 8 bits + stop
  localparam int SHW       = 18;             // start + 16 bits + stop
  localparam int MAXT      = (ATTN_US > GAP_US) ? ATTN_US : GAP_US;
  localparam int CW        = $clog2(MAXT + 1);
  localparam int LW        = $clog2(SHW + 1);

  phase_e           phase_q, phase_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [SHW-1:0]   sh_q, sh_d;
  logic [SHW-1:0]   dat_q, dat_d;
  logic [LW-1:0]    left_q, left_d;
  logic [LW-1:0]    dcells_q, dcells_d;
  logic             has_data_q, has_data_d;
  logic             attn_low_q, attn_low_d;
  logic             busy_q, busy_d;

  logic             tick;
  logic             accept;
  logic             go;
  logic             go_bit;
  logic             cell_low;
  logic             cell_done;
  logic [1:0]       nbytes;
  logic [SHW-1:0]   dframe;
  logic [LW-1:0]    dcells;

  swb_tick_div #(.DIV(CLK_PER_US)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (accept),
    .tick_o (tick)
  );

  swb_bit_cell #(
    .CELL_US    (CELL_US),
    .ONE_LO_US  (ONE_LO_US),
    .ZERO_LO_US (ZERO_LO_US)
  ) u_cell (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick),
    .go_i   (go),
    .bit_i  (go_bit),
    .low_o  (cell_low),
    .done_o (cell_done)
  );

  assign accept      = start_i && !busy_q;
  assign busy_o      = busy_q;
  assign drive_low_o = attn_low_q || cell_low;

  // Data byte count: only Listen carries data, 3 clamps to 2
  always_comb begin
    if (code_i != CODE_LISTEN) nbytes = 2'd0;
    else if (len_i == 2'd3)    nbytes = 2'd2;
    else                       nbytes = len_i;
  end

  always_comb begin
    unique case (nbytes)
      2'd1:    dframe = {1'b1, data0_i, 1'b0, 8'h00};
      2'd2:    dframe = {1'b1, data0_i, data1_i, 1'b0};
      default: dframe = '0;
    endcase
    dcells = LW'(2) + LW'({nbytes, 3'b000});
  end

  always_comb begin
    phase_d    = phase_q;
    cnt_d      = cnt_q;
    sh_d       = sh_q;
    dat_d      = dat_q;
    left_d     = left_q;
    dcells_d   = dcells_q;
    has_data_d = has_data_q;
    attn_low_d = attn_low_q;
    busy_d     = busy_q;
    go         = 1'b0;
    go_bit     = sh_q[SHW-1];

    unique case (phase_q)
      PH_IDLE: begin
        if (accept) begin
          phase_d    = PH_ATTN;
          busy_d     = 1'b1;
          attn_low_d = 1'b1;
          cnt_d      = '0;
          sh_d       = {1'b1, pack_cmd(addr_i, code_i, reg_i), 1'b0, 8'h00};
          left_d     = LW'(CMD_CELLS);
          dat_d      = dframe;
          dcells_d   = dcells;
          has_data_d = (nbytes != 2'd0);
        end
      end
      PH_ATTN: begin
        if (tick) begin
          if (cnt_q == CW'(ATTN_US-1)) begin
            attn_low_d = 1'b0;
            go         = 1'b1;
            sh_d       = sh_q << 1;
            left_d     = left_q - 1'b1;
            phase_d    = PH_CMD;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      PH_CMD, PH_DATA: begin
        if (cell_done) begin
          if (left_q != '0) begin
            go     = 1'b1;
            sh_d   = sh_q << 1;
            left_d = left_q - 1'b1;
          end else if (phase_q == PH_CMD && has_data_q) begin
            phase_d = PH_GAP;
            cnt_d   = '0;
          end else begin
            phase_d = PH_IDLE;
            busy_d  = 1'b0;
          end
        end
      end
      PH_GAP: begin
        if (tick) begin
          if (cnt_q == CW'(GAP_US-1)) begin
            go      = 1'b1;
            go_bit  = dat_q[SHW-1];
            sh_d    = dat_q << 1;
            left_d  = dcells_q - 1'b1;
            phase_d = PH_DATA;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: begin
        phase_d = PH_IDLE;
        busy_d  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_IDLE;
      cnt_q      <= '0;
      sh_q       <= '0;
      dat_q      <= '0;
      left_q     <= '0;
      dcells_q   <= '0;
      has_data_q <= 1'b0;
      attn_low_q <= 1'b0;
      busy_q     <= 1'b0;
    end else begin
      phase_q    <= phase_d;
      cnt_q      <= cnt_d;
      sh_q       <= sh_d;
      dat_q      <= dat_d;
      left_q     <= left_d;
      dcells_q   <= dcells_d;
      has_data_q <= has_data_d;
      attn_low_q <= attn_low_d;
      busy_q     <= busy_d;
    end
  end

  // R1
  idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !drive_low_o);

  // R2
  accept_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy_q |=> busy_q && drive_low_o);

  // R3
  attn_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ATTN) |-> drive_low_o);

  // R7
  gap_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_GAP) |-> !drive_low_o);

  // R6
  end_after_cells_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ($past(phase_q) == PH_CMD || $past(phase_q) == PH_DATA));

endmodule

// File: tb/swb_host_tx_tb.sv
module swb_host_tx_tb;

  localparam int P = 2;   // clocks per microsecond in this bench

  logic       clk;
  logic       rst_n;
  logic       start_i;
  logic [3:0] addr_i;
  logic [1:0] code_i;
  logic [1:0] reg_i;
  logic [1:0] len_i;
  logic [7:0] data0_i;
  logic [7:0] data1_i;
  logic       busy_o;
  logic       drive_low_o;

  int n_checks = 0;
  int n_fail   = 0;

  // scoreboard: expected line runs (level, cycles, requirement)
  bit    exp_lvl[$];
  int    exp_cyc[$];
  string exp_req[$];

  bit    pend_valid;
  bit    pend_lvl;
  int    pend_cyc;
  string pend_req;

  swb_host_tx #(
    .CLK_PER_US (P)
  ) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .addr_i      (addr_i),
    .code_i      (code_i),
    .reg_i       (reg_i),
    .len_i       (len_i),
    .data0_i     (data0_i),
    .data1_i     (data1_i),
    .busy_o      (busy_o),
    .drive_low_o (drive_low_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  task automatic add_seg(input bit lvl, input int us, input string req);
    if (pend_valid && pend_lvl == lvl) begin
      pend_cyc += us * P;
    end else begin
      if (pend_valid) begin
        exp_lvl.push_back(pend_lvl);
        exp_cyc.push_back(pend_cyc);
        exp_req.push_back(pend_req);
      end
      pend_valid = 1'b1;
      pend_lvl   = lvl;
      pend_cyc   = us * P;
      pend_req   = req;
    end
  endtask

  task automatic add_cell(input bit b, input string req);
    add_seg(1'b1, b ? 35 : 65, req);
    add_seg(1'b0, b ? 65 : 35, req);
  endtask

  task automatic flush_pend();
    if (pend_valid) begin
      exp_lvl.push_back(pend_lvl);
      exp_cyc.push_back(pend_cyc);
      exp_req.push_back(pend_req);
    end
    pend_valid = 1'b0;
  endtask

  // Driver: build the expected run list, then issue the request
  task automatic send(input logic [3:0] a, input logic [1:0] c, input logic [1:0] r,
                      input logic [1:0] l, input logic [7:0] d0, input logic [7:0] d1,
                      input bit poke);
    logic [7:0] cmd;
    int         nb;
    int         cyc;
    string      dtag;
    string      etag;
    cmd  = {a, c, r};
    nb   = (c != 2'b10) ? 0 : (l == 2'd3) ? 2 : int'(l);
    dtag = (l == 2'd3) ? "R9" : "R7";
    etag = (nb == 0) ? "R8" : dtag;
    pend_valid = 1'b0;
    add_seg(1'b1, 765, "R3");
    add_cell(1'b1, "R3");
    for (int i = 7; i >= 0; i--) add_cell(cmd[i], "R5");
    add_cell(1'b0, (nb == 0) ? "R6" : "R7");
    if (nb > 0) begin
      add_seg(1'b0, 200, "R7");
      add_cell(1'b1, dtag);
      for (int i = 7; i >= 0; i--) add_cell(d0[i], dtag);
      if (nb == 2) for (int i = 7; i >= 0; i--) add_cell(d1[i], dtag);
      add_cell(1'b0, dtag);
    end
    flush_pend();

    @(negedge clk);
    addr_i = a; code_i = c; reg_i = r; len_i = l; data0_i = d0; data1_i = d1;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    // R2: accepted at the edge, busy and line low right away
    chk(busy_o === 1'b1, "R2", int'(busy_o), 1);
    chk(drive_low_o === 1'b1, "R2", int'(drive_low_o), 1);
    cyc = 0;
    while (busy_o === 1'b1) begin
      @(negedge clk);
      cyc++;
      if (poke && (cyc == 300 || cyc == 2500)) begin
        // R2: a mid-frame request with other fields must be ignored
        addr_i = ~a; code_i = ~c; reg_i = ~r; len_i = 2'd2;
        data0_i = ~d0; data1_i = ~d1;
        start_i = 1'b1;
      end else begin
        start_i = 1'b0;
      end
    end
    start_i = 1'b0;
    repeat (6) @(negedge clk);
    chk(exp_cyc.size() == 0, etag, exp_cyc.size(), 0);
    // R1: released after the frame
    chk(drive_low_o === 1'b0 && busy_o === 1'b0, "R1", int'(drive_low_o), 0);
    exp_lvl.delete(); exp_cyc.delete(); exp_req.delete();
  endtask

  // Monitor: measure line runs while busy and compare with the scoreboard
  bit in_frame = 1'b0;
  bit prev_lvl = 1'b0;
  int run_len  = 0;

  task automatic emit(input bit lvl, input int len);
    if (exp_cyc.size() == 0) begin
      chk(1'b0, "R8", len, 0);
    end else begin
      bit    el;
      int    ec;
      string er;
      el = exp_lvl.pop_front();
      ec = exp_cyc.pop_front();
      er = exp_req.pop_front();
      chk(el == lvl, er, int'(lvl), int'(el));
      chk(ec == len, er, len, ec);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (!in_frame) begin
        if (busy_o === 1'b1) begin
          in_frame = 1'b1;
          prev_lvl = drive_low_o;
          run_len  = 1;
        end
      end else if (busy_o !== 1'b1) begin
        emit(prev_lvl, run_len);
        in_frame = 1'b0;
      end else if (drive_low_o == prev_lvl) begin
        run_len++;
      end else begin
        emit(prev_lvl, run_len);
        prev_lvl = drive_low_o;
        run_len  = 1;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; addr_i = '0; code_i = '0; reg_i = '0;
    len_i = '0; data0_i = '0; data1_i = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy_o === 1'b0, "R1", int'(busy_o), 0);
    chk(drive_low_o === 1'b0, "R1", int'(drive_low_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(busy_o === 1'b0 && drive_low_o === 1'b0, "R1", int'(busy_o), 0);

    send(4'h2, 2'b10, 2'b11, 2'd2, 8'h02, 8'h03, 1'b0);  // R5 R7 Listen two bytes
    send(4'hF, 2'b11, 2'b00, 2'd2, 8'hFF, 8'h11, 1'b1);  // R8 Talk, R2 poke
    send(4'h0, 2'b00, 2'b00, 2'd0, 8'h00, 8'h00, 1'b0);  // R8 flush
    send(4'h6, 2'b01, 2'b11, 2'd2, 8'h77, 8'h88, 1'b0);  // R8 reserved code
    send(4'h5, 2'b10, 2'b01, 2'd0, 8'hEE, 8'hDD, 1'b0);  // R8 Listen no data
    send(4'hA, 2'b10, 2'b10, 2'd1, 8'hA5, 8'h3C, 1'b0);  // R7 one byte
    send(4'h3, 2'b10, 2'b00, 2'd3, 8'h5A, 8'hC3, 1'b1);  // R9 clamp, R2 poke

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule